// File: doc/BRIEF.md
# SMBus Register Slave with Block Access

This block is a two-wire serial slave that exposes a small bank of thirteen 8-bit control and status registers to an external bus master. It watches the clock and data lines through two-stage synchronizers on the system clock, detects START and STOP conditions, and matches the 7-bit device address 0x69. Address bytes on the wire are 0xD2 for writes and 0xD3 for reads. The slave acknowledges and returns read data by pulling the data line low through an open-drain enable. Clock stretching is not used.

Two access styles share the same slave. In byte-data access, a command byte of 0x80 plus an index selects one register. In block access, a command byte of 0x00 selects the whole bank. A block write carries a byte count and then data for consecutive registers starting at index 0. A block read returns the bank size and then the registers in order. Each accepted data byte is reported to the rest of the chip as a one-cycle write strobe with index and data. Some bits read back live strap and status inputs, two registers hold constant identification codes, and writes to all of these bits are dropped.

Top module: `smb_regbank_slave`

## Requirements
- R1: Address byte 0xD2 (write) or 0xD3 (read), bit 0 being the direction, is acknowledged. Any other address is not acknowledged, and the slave leaves SDA undriven until the next START.
- R2: The slave changes its SDA drive only while SCL is low. It holds SDA low for the whole ninth SCL period to acknowledge, and it sends read bytes most significant bit first.
- R3: Command byte 0x00 selects block mode. Command 0x80+n, with n from 0 to 12, selects byte access to register n. Every other command is not acknowledged, and the rest of that transfer is ignored.
- R4: A byte write (address, command 0x80+n, one data byte) updates register n. A further data byte in the same transfer is not acknowledged and not written.
- R5: Every accepted data byte raises wr_stb for exactly one clock cycle, with wr_addr set to the register index and wr_data set to the received byte.
- R6: A byte read is sent as write address, command 0x80+n, repeated START, then read address. It returns register n, then n+1 and onward while the master acknowledges. After the master's NACK, the slave releases SDA.
- R7: A block write is sent as command 0x00, then a count, then data bytes. The data bytes fill registers 0, 1, 2 and so on. A byte past the count, or past register 12, is not acknowledged and not written.
- R8: A block read is sent as command 0x00, repeated START, then read address. It returns the count 13 and then registers 0 to 12 in order.
- R9: A STOP at any point ends the transfer and returns the slave to idle. A START at any point returns it to waiting for an address. The last accepted command is kept, and no partial byte is written.
- R10: Reset values are:
  - register 0: 0x00
  - register 1: 0xE0 with the strap bits added
  - register 2: 0x7F with the strap bit added
  - register 3: 0xF7
  - register 4: 0xFF
  - register 5: 0x00 with the status bit added
  - register 6: 0x08
  - register 7: 0x40
  - register 8: 0x00
  - register 9: 0x1F
  - register 10: 0x04
- R11: These bits read live inputs, and writes to them have no effect:
  - register 1 bits 4:0 read strap_fs.
  - register 2 bit 7 reads strap_cur.
  - register 5 bit 5 reads fault_flag.
  - register 11 always reads 0x32.
  - register 12 always reads 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap_fs | input | 5 | Latched frequency strap value, read back in register 1 |
| strap_cur | input | 1 | Latched current-mode strap, read back in register 2 |
| fault_flag | input | 1 | Live status bit, read back in register 5 |
| wr_stb | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr | output | 4 | Register index of the accepted byte |
| wr_data | output | 8 | Data byte as received |
| regs_q | output | 104 | Stored writable bits of all registers, register i at bits 8i+7:8i |

## Verification
The bench sweeps byte writes with several patterns over every index, including the read-only identification registers. A slave that got the write masks wrong would change ID or strap bits. One that mixed up the index would corrupt a neighbour. Block writes are run with a short count, an exact count and a count past the bank end. These catch a slave that keeps acknowledging after the count runs out, or that writes past register 12. Transfers cut short by STOP or by a repeated START in the middle of a data byte catch a slave that commits a half-received byte or forgets the command. A foreign address followed by traffic shows whether the slave ever pulls SDA when it should stay silent.

// File: rtl/smb_regbank_slave.sv
`timescale 1ns/1ps
module smb_regbank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         SYNC     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_in,
  input  logic         sda_in,
  output logic         sda_oe,
  input  logic [4:0]   strap_fs,
  input  logic         strap_cur,
  input  logic         fault_flag,
  output logic         wr_stb,
  output logic [3:0]   wr_addr,
  output logic [7:0]   wr_data,
  output logic [103:0] regs_q
);
  localparam int         NREG = 13;
  localparam logic [4:0] NR   = 5'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDATA, S_TX} st_t;

  function automatic logic [7:0] wmask(input int i);
    case (i)
      1:       return 8'hE0;
      2:       return 8'h7F;
      5:       return 8'hDF;
      11, 12:  return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rstv(input int i);
    case (i)
      1:       return 8'hE0;
      2:       return 8'h7F;
      3:       return 8'hF7;
      4:       return 8'hFF;
      6:       return 8'h08;
      7:       return 8'h40;
      9:       return 8'h1F;
      10:      return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic            scl_p, sda_p;
  wire scl_s   = scl_sy[SYNC-1];
  wire sda_s   = sda_sy[SYNC-1];
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC-2:0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end

  st_t        st;
  logic [3:0] cnt, cidx;
  logic [7:0] sh, tx, left;
  logic [4:0] ptr;
  logic       blk, mack, first;
  logic [7:0] mem  [NREG];
  logic [7:0] view [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) view[i] = mem[i] & wmask(i);
    view[1][4:0] = strap_fs;
    view[2][7]   = strap_cur;
    view[5][5]   = fault_flag;
    view[11]     = 8'h32;
    view[12]     = 8'h11;
  end

  wire [7:0] at_ptr = (ptr < NR) ? view[ptr[3:0]] : 8'h00;
  wire [7:0] nb     = first ? (blk ? 8'(NREG) : view[cidx]) : at_ptr;
  wire       cmd_ok = sh[7] && sh[6:4] == 3'd0 && {1'b0, sh[3:0]} < NR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cidx <= '0; sh <= '0; tx <= '0; left <= '0;
      ptr <= '0; blk <= 1'b0; mack <= 1'b0; first <= 1'b0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; cnt <= '0;
      end else if (start_c) begin
        st <= S_ADDR; sda_oe <= 1'b0; cnt <= '0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_s;
            cnt  <= 4'd9;
          end
        end else if (fall) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            case (st)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  first  <= 1'b1;
                  st     <= sh[0] ? S_TX : S_CMD;
                end else st <= S_IDLE;
              S_CMD:
                if (sh == 8'h00) begin
                  sda_oe <= 1'b1; blk <= 1'b1; st <= S_CNT;
                end else if (cmd_ok) begin
                  sda_oe <= 1'b1; blk <= 1'b0; cidx <= sh[3:0];
                  ptr <= {1'b0, sh[3:0]}; left <= 8'd1; st <= S_WDATA;
                end else st <= S_IDLE;
              S_CNT: begin
                sda_oe <= 1'b1; left <= sh; ptr <= '0; st <= S_WDATA;
              end
              S_WDATA:
                if (left != 8'd0 && ptr < NR) begin
                  sda_oe  <= 1'b1;
                  wr_stb  <= 1'b1;
                  wr_addr <= ptr[3:0];
                  wr_data <= sh;
                  ptr     <= ptr + 5'd1;
                  left    <= left - 8'd1;
                end else st <= S_IDLE;
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            if (st == S_TX) begin
              if (first || mack) begin
                tx     <= nb;
                sda_oe <= ~nb[7];
                first  <= 1'b0;
                if (first) ptr <= blk ? 5'd0 : {1'b0, cidx} + 5'd1;
                else if (ptr < NR) ptr <= ptr + 5'd1;
              end else st <= S_IDLE;
            end
          end else if (st == S_TX && cnt != 4'd0) begin
            sda_oe <= ~tx[3'd7 - cnt[2:0]];
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= rstv(i);
    end else if (wr_stb) begin
      mem[wr_addr] <= (mem[wr_addr] & ~wmask(int'(wr_addr))) | (wr_data & wmask(int'(wr_addr)));
    end

  for (genvar g = 0; g < NREG; g++) begin : g_img
    assign regs_q[g*8 +: 8] = mem[g];
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);
  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_p);
  assert_ack_ninth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (cnt == 4'd8 || st == S_TX));
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_strobe_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> {1'b0, wr_addr} < NR);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe));
  assert_start_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_ADDR && cnt == 4'd0));
endmodule

// File: tb/test_smb_regbank_slave.sv
`timescale 1ns/1ps
module test_smb_regbank_slave;
  localparam int Q = 5;
  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic [4:0] strap_fs = 5'h15;
  logic strap_cur = 1, fault_flag = 0;
  logic sda_oe, wr_stb;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [103:0] regs_q;
  wire sda_line = sda_m & ~sda_oe;

  smb_regbank_slave i_smb_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_fs(strap_fs), .strap_cur(strap_cur), .fault_flag(fault_flag),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .regs_q(regs_q));

  always #2 clk = ~clk;

  int nvec = 0, nbad = 0, stb_cnt = 0;
  logic [3:0] stb_addr = 0;
  logic [7:0] stb_data = 0;
  logic oe_seen = 0;
  logic [7:0] model [13];
  bit done = 0;

  always @(posedge clk) begin
    if (wr_stb) begin stb_cnt <= stb_cnt + 1; stb_addr <= wr_addr; stb_data <= wr_data; end
    if (sda_oe) oe_seen <= 1;
  end

  function automatic logic [7:0] m_mask(int i);
    case (i) 1: return 8'hE0; 2: return 8'h7F; 5: return 8'hDF;
      11, 12: return 8'h00; default: return 8'hFF; endcase
  endfunction
  function automatic logic [7:0] m_rst(int i);
    case (i) 1: return 8'hE0; 2: return 8'h7F; 3: return 8'hF7; 4: return 8'hFF;
      6: return 8'h08; 7: return 8'h40; 9: return 8'h1F; 10: return 8'h04;
      default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] exp_rd(int i);
    logic [7:0] v = model[i] & m_mask(i);
    if (i == 1) v[4:0] = strap_fs;
    if (i == 2) v[7] = strap_cur;
    if (i == 5) v[5] = fault_flag;
    if (i == 11) v = 8'h32;
    if (i == 12) v = 8'h11;
    return v;
  endfunction
  function automatic void m_write(int i, logic [7:0] d);
    model[i] = (model[i] & ~m_mask(i)) | (d & m_mask(i));
  endfunction

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start; sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q); endtask
  task automatic bus_stop; sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q); endtask
  task automatic put_bit(bit b); sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); endtask
  task automatic get_bit(output bit b); sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q); endtask
  task automatic send(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b); ack = !b;
  endtask
  task automatic recv(output logic [7:0] v, input bit ack_it);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!ack_it);
  endtask

  task automatic byte_write(int idx, logic [7:0] val, output bit ok);
    bit a0, a1, a2;
    bus_start; send(8'hD2, a0); send(8'h80 | 8'(idx), a1); send(val, a2); bus_stop;
    ok = a0 & a1 & a2;
  endtask
  task automatic byte_read(int idx, output logic [7:0] v);
    bit a;
    bus_start; send(8'hD2, a); send(8'h80 | 8'(idx), a);
    bus_start; send(8'hD3, a); recv(v, 0); bus_stop;
  endtask
  task automatic block_read_check(string tag);
    bit a; logic [7:0] v;
    bus_start; send(8'hD2, a); send(8'h00, a);
    bus_start; send(8'hD3, a); recv(v, 1);
    chk({tag, " R8 count"}, v, 13);
    for (int i = 0; i < 13; i++) begin
      recv(v, i != 12);
      chk($sformatf("%s R8 block byte %0d", tag, i), v, exp_rd(i));
    end
    chk({tag, " R6 release after nack"}, sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    bit ok, a;
    logic [7:0] v;
    int s0;
    for (int i = 0; i < 13; i++) model[i] = m_rst(i);
    tick(10);
    chk("R10 sda released in reset", sda_oe, 0);
    rst_n = 1;
    tick(10);
    chk("R10 regs_q reg3 reset", regs_q[31:24], 8'hF7);
    block_read_check("R10 reset image");

    for (int s = 0; s < 32; s++) begin
      strap_fs = 5'(s);
      byte_read(1, v);
      chk($sformatf("R11 strap readback %0d", s), v, exp_rd(1));
    end
    strap_cur = 0; fault_flag = 1;
    byte_read(2, v); chk("R11 strap_cur bit", v, exp_rd(2));
    byte_read(5, v); chk("R11 fault bit", v, exp_rd(5));

    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 13; i++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'(i * 8'h2B + 8'h11);
        s0 = stb_cnt;
        byte_write(i, d, ok);
        chk($sformatf("R4 byte write ack reg %0d", i), ok, 1);
        chk($sformatf("R5 strobe count reg %0d", i), stb_cnt - s0, 1);
        chk($sformatf("R5 strobe addr reg %0d", i), stb_addr, i);
        chk($sformatf("R5 strobe data reg %0d", i), stb_data, d);
        m_write(i, d);
        byte_read(i, v);
        chk($sformatf("R4 R11 readback reg %0d pat %0d", i, p), v, exp_rd(i));
      end

    s0 = stb_cnt;
    bus_start; send(8'hD2, a); send(8'h83, a); send(8'h3C, a);
    chk("R4 first data ack", a, 1);
    send(8'hC3, a); bus_stop;
    chk("R4 second data nack", a, 0);
    chk("R4 single strobe", stb_cnt - s0, 1);
    m_write(3, 8'h3C);
    byte_read(3, v); chk("R4 extra byte not written", v, exp_rd(3));

    bus_start; send(8'hD2, a); send(8'h8A, a);
    bus_start; send(8'hD3, a); chk("R1 read address ack", a, 1);
    recv(v, 1); chk("R6 seq reg10", v, exp_rd(10));
    recv(v, 1); chk("R6 seq reg11", v, exp_rd(11));
    recv(v, 0); chk("R6 seq reg12", v, exp_rd(12));
    chk("R6 released after nack", sda_oe, 0);
    bus_stop;

    bus_start; send(8'hD2, a); send(8'h00, a); send(8'd13, a);
    for (int i = 0; i < 13; i++) begin
      send(8'(8'h30 + 8'(i * 7)), a);
      chk($sformatf("R7 block data ack %0d", i), a, 1);
      m_write(i, 8'(8'h30 + 8'(i * 7)));
    end
    bus_stop;
    block_read_check("R7 full block");

    s0 = stb_cnt;
    bus_start; send(8'hD2, a); send(8'h00, a); send(8'd3, a);
    for (int i = 0; i < 4; i++) begin
      send(8'(8'hA0 + i), a);
      chk($sformatf("R7 short count ack %0d", i), a, i < 3);
      if (i < 3) m_write(i, 8'(8'hA0 + i));
    end
    bus_stop;
    chk("R7 short count strobes", stb_cnt - s0, 3);
    block_read_check("R7 short block");

    bus_start; send(8'hD2, a); send(8'h00, a); send(8'd20, a);
    for (int i = 0; i < 14; i++) begin
      send(8'(8'h5A ^ i), a);
      chk($sformatf("R7 long count ack %0d", i), a, i < 13);
      if (i < 13) m_write(i, 8'(8'h5A ^ i));
    end
    bus_stop;
    block_read_check("R7 long block");

    oe_seen = 0; s0 = stb_cnt;
    bus_start; send(8'hD4, a); chk("R1 foreign address nack", a, 0);
    send(8'h81, a); send(8'h00, a); bus_stop;
    bus_start; send(8'h52, a); chk("R1 low-bit alias nack", a, 0);
    send(8'h00, a); bus_stop;
    chk("R1 never drove sda", oe_seen, 0);
    chk("R1 no strobe", stb_cnt - s0, 0);

    s0 = stb_cnt;
    bus_start; send(8'hD2, a); send(8'h05, a); chk("R3 bad command nack", a, 0);
    send(8'h77, a); bus_stop;
    bus_start; send(8'hD2, a); send(8'h8D, a); chk("R3 index 13 nack", a, 0);
    bus_stop;
    chk("R3 no strobe", stb_cnt - s0, 0);

    s0 = stb_cnt;
    bus_start; send(8'hD2, a); send(8'h84, a);
    put_bit(1); put_bit(0); put_bit(1); bus_stop;
    chk("R9 stop abort no strobe", stb_cnt - s0, 0);
    byte_read(4, v); chk("R9 stop abort reg4 kept", v, exp_rd(4));

    s0 = stb_cnt;
    bus_start; send(8'hD2, a); send(8'h86, a);
    put_bit(0); put_bit(1); put_bit(1); put_bit(0);
    bus_start; send(8'hD3, a); chk("R9 restart address ack", a, 1);
    recv(v, 0); bus_stop;
    chk("R9 command kept over restart", v, exp_rd(6));
    chk("R9 restart abort no strobe", stb_cnt - s0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule